// File: doc/BRIEF.md
# Control Register File with Configuration Download

This block is a byte-wide control port with eight registers, selected by a 3-bit register address. A host reaches a bank of sixteen indirect registers through an index register and a data register. A command register accepts one-byte commands. One command switches that same register into a download channel: it takes a low address byte, then a high address byte, then a stream of data bytes. The data bytes go into a configuration RAM whose address steps up by one after each byte. The host can read the RAM back the same way, and reading also steps the address.

The block drives a bit-banged I2C clock and data pair for an external EEPROM, and it presents a global status register. That register merges live interrupt inputs with a context flag, and reading it clears the flag. The outputs are a codec reset pulse, a wavetable enable, an FM enable, a plug-and-play enable level, and one-cycle pulses that ask downstream logic to reload hardware configuration or resource data, or to turn off the key-unlock engine.

The host port is a plain register bus with no back-pressure. A write or read completes in the cycle its strobe is high. Read data is combinational from the address, and read side effects happen at the clock edge that ends the cycle. There are no streaming interfaces.

Top module: `cfg_ctrl_port`

## Requirements
- R1: Register 3 stores only the low 4 bits of a write, and bits 7:4 read as 0. A register 4 read returns the indirect register that register 3 selects, and a register 4 write targets that register.
- R2: In command mode, a register 5 write of 0xAA starts a download. The next register 5 write loads the low address byte and the one after loads the high address byte. Every later register 5 write stores the byte at the current address and then increments the 16-bit address. RAM storage is indexed by the low RAM_AW address bits (default 12), so addresses equal modulo 4096 alias.
- R3: In the data phase, a register 5 read returns the RAM byte at the current address and increments the address. Outside the data phase, a register 5 read returns the last byte written to register 5. A read that coincides with a write has no side effect.
- R4: A register 6 write of 0x00 or 0x40 returns register 5 to command mode and pulses resdata_upd_o for one cycle, starting the cycle after the write. Any other value is only stored and read back, and the download phase is kept.
- R5: The command-mode codes are as follows. 0x5A pulses hwcfg_upd_o. 0x55 drops pnp_en_o to 0 and pulses hwcfg_upd_o. 0x56 pulses key_off_o. 0x57 and every other code have no effect.
- R6: A write to indirect index 0 stores 0, and when bit 7 of the write is set it also pulses codec_rst_o for one cycle. Writes to indexes 1, 7 and 9 to 15 are ignored. Index 1 reads CHIP_ID.
- R7: With EXT_IDX=1, indexes 2 to 6 are writable, with masks 0xFF (index 2), 0xE0 (index 3), 0xF0 (index 4), 0xFE (index 5) and 0xFF (index 6). With EXT_IDX=0 these writes are ignored. Index 8 is masked to 0x0F, and its bit 3 is wavetable_en_o.
- R8: A hardware-config update (0x55 or 0x5A) applies the byte last downloaded to address HWCFG_ADDR (0x4003). Its bit 3 goes to index 8 bit 3. Its bit 2 goes to index 8 bit 2 when SPS_COPY=1. Its bit 7 goes to fm_en_o. The new values are visible while hwcfg_upd_o is high. A download to an alias of that address does not change the captured byte.
- R9: A register 7 read returns {ctx, flag, irq_sb_i, irq_wss_i, irq_midi_i, 3'b000} and clears the flag afterwards. A ctx_evt_i cycle toggles ctx and sets the flag, and it takes priority over a clearing read in the same cycle. Writes to register 7 are ignored.
- R10: A register 1 write with bit 2 set drives i2c_scl_o from bit 0 and i2c_sda_o from bit 1. With bit 2 clear, both lines hold their values. A register 1 read returns bit 2 as stored bit 2 AND i2c_sda_i.
- R11: While reset is held, register 1 reads 0x80, the other direct registers and the indirect bank read 0 (index 1 reads CHIP_ID), register 5 is in command mode, the I2C lines are high, pnp_en_o is 1, and both hwcfg_upd_o and resdata_upd_o are 1. The update pulses fall at the first clock after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| i2c_scl_o | output | 1 | EEPROM I2C clock line |
| i2c_sda_o | output | 1 | EEPROM I2C data line drive |
| i2c_sda_i | input | 1 | Sampled EEPROM I2C data line |
| irq_midi_i | input | 1 | Live MIDI interrupt |
| irq_wss_i | input | 1 | Live codec interrupt |
| irq_sb_i | input | 1 | Live legacy-audio interrupt |
| ctx_evt_i | input | 1 | Context switch event: toggles ctx and sets the flag |
| codec_rst_o | output | 1 | One-cycle codec reset pulse |
| wavetable_en_o | output | 1 | Wavetable enable |
| fm_en_o | output | 1 | FM enable |
| pnp_en_o | output | 1 | Plug-and-play enable level |
| hwcfg_upd_o | output | 1 | Hardware-config update pulse |
| resdata_upd_o | output | 1 | Resource-data update pulse |
| key_off_o | output | 1 | Key-unlock disable pulse |

## Verification
The hardest case to reach from the ports is a hardware-config update that picks up the right byte. That byte only exists after a full download sequence (0xAA, low address, high address, data) lands exactly on address 0x4003, followed by a command in a separate command-mode phase. The stimulus therefore downloads a stream that starts at 0x4003. It then downloads to address 0x0003, which aliases 0x4003 in storage, and confirms that the captured byte is unchanged. The update is triggered only after that, while the reference model tracks the phase, the address and the RAM contents on every clock. Read-back of the aliased location and a status read that coincides with a context event cover the remaining orderings.

// File: rtl/cfg_ctrl_pkg.sv
`timescale 1ns/1ps
package cfg_ctrl_pkg;
  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_ALO  = 2'd1,
    PH_AHI  = 2'd2,
    PH_DATA = 2'd3
  } dl_phase_e;

  localparam logic [7:0] CMD_DOWNLOAD = 8'hAA;
  localparam logic [7:0] CMD_HWCFG    = 8'h5A;
  localparam logic [7:0] CMD_PNPOFF   = 8'h55;
  localparam logic [7:0] CMD_KEYOFF   = 8'h56;
  localparam logic [7:0] END_CODE_A   = 8'h00;
  localparam logic [7:0] END_CODE_B   = 8'h40;

  localparam int NUM_REGS = 8;
  localparam int NUM_IDX  = 16;
endpackage

// File: rtl/cfg_dl_channel.sv
`timescale 1ns/1ps
module cfg_dl_channel
  import cfg_ctrl_pkg::*;
#(
  parameter int          RAM_AW     = 12,
  parameter logic [15:0] HWCFG_ADDR = 16'h4003
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr5,
  input  logic       rd5,
  input  logic       wr6,
  input  logic [7:0] wdata,
  output logic       in_data_o,
  output logic [7:0] ram_rd_o,
  output logic       cmd_hw_o,
  output logic       cmd_pnpoff_o,
  output logic       cmd_keyoff_o,
  output logic       res_upd_o,
  output logic [2:0] hw_bits_o
);
  localparam int RAM_DEPTH = 1 << RAM_AW;

  dl_phase_e   phase;
  logic [15:0] dl_addr;
  logic [7:0]  mem [RAM_DEPTH];
  logic        in_cmd;
  logic        end_code;

  assign in_cmd    = (phase == PH_CMD);
  assign in_data_o = (phase == PH_DATA);
  assign end_code  = (wdata == END_CODE_A) || (wdata == END_CODE_B);

  assign cmd_hw_o     = wr5 && in_cmd && ((wdata == CMD_HWCFG) || (wdata == CMD_PNPOFF));
  assign cmd_pnpoff_o = wr5 && in_cmd && (wdata == CMD_PNPOFF);
  assign cmd_keyoff_o = wr5 && in_cmd && (wdata == CMD_KEYOFF);
  assign res_upd_o    = wr6 && end_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_CMD;
      dl_addr   <= '0;
      hw_bits_o <= '0;
    end else if (wr6) begin
      if (end_code) phase <= PH_CMD;
    end else if (wr5) begin
      unique case (phase)
        PH_CMD:  if (wdata == CMD_DOWNLOAD) phase <= PH_ALO;
        PH_ALO:  begin dl_addr <= {8'h00, wdata}; phase <= PH_AHI; end
        PH_AHI:  begin dl_addr[15:8] <= wdata; phase <= PH_DATA; end
        PH_DATA: begin
          if (dl_addr == HWCFG_ADDR) hw_bits_o <= {wdata[7], wdata[3], wdata[2]};
          dl_addr <= dl_addr + 16'd1;
        end
      endcase
    end else if (rd5 && in_data_o) begin
      dl_addr <= dl_addr + 16'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr5 && in_data_o) mem[dl_addr[RAM_AW-1:0]] <= wdata;
  end

  assign ram_rd_o = mem[dl_addr[RAM_AW-1:0]];

  p_lo_then_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr5 && phase == PH_ALO) |=> (phase == PH_AHI));
  p_wr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr5 && in_data_o) |=> (in_data_o && dl_addr == $past(dl_addr) + 16'd1));
  p_rd_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd5 && !wr5 && !wr6 && in_data_o) |=> (dl_addr == $past(dl_addr) + 16'd1));
  p_end_to_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_upd_o |=> (phase == PH_CMD));
endmodule

// File: rtl/cfg_idx_bank.sv
`timescale 1ns/1ps
module cfg_idx_bank
  import cfg_ctrl_pkg::*;
#(
  parameter logic [7:0] CHIP_ID  = 8'h5C,
  parameter bit         EXT_IDX  = 1'b1,
  parameter bit         SPS_COPY = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] idx,
  input  logic [7:0] wdata,
  input  logic       hw_apply,
  input  logic       hw_wt,
  input  logic       hw_sps,
  output logic [7:0] rd_data,
  output logic       codec_rst_req,
  output logic       wt_en
);
  logic [7:0] bank [NUM_IDX];

  function automatic logic [8:0] wr_rule(input logic [3:0] i);
    case (i)
      4'd0:        wr_rule = {1'b1, 8'h00};
      4'd2, 4'd6:  wr_rule = {EXT_IDX, 8'hFF};
      4'd3:        wr_rule = {EXT_IDX, 8'hE0};
      4'd4:        wr_rule = {EXT_IDX, 8'hF0};
      4'd5:        wr_rule = {EXT_IDX, 8'hFE};
      4'd8:        wr_rule = {1'b1, 8'h0F};
      default:     wr_rule = {1'b0, 8'h00};
    endcase
  endfunction

  logic [8:0] rule;
  assign rule          = wr_rule(idx);
  assign codec_rst_req = wr_en && (idx == 4'd0) && wdata[7];
  assign rd_data       = bank[idx];
  assign wt_en         = bank[8][3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_IDX; i++) bank[i] <= (i == 1) ? CHIP_ID : 8'h00;
    end else if (wr_en && rule[8]) begin
      bank[idx] <= wdata & rule[7:0];
    end else if (hw_apply) begin
      bank[8][3] <= hw_wt;
      if (SPS_COPY) bank[8][2] <= hw_sps;
    end
  end

  p_idx0_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == 4'd0) |=> (bank[0] == 8'h00));
  p_idx8_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == 4'd8) |=> (bank[8][7:4] == 4'h0));
  p_wt_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_apply && !wr_en) |=> (wt_en == $past(hw_wt)));
endmodule

// File: rtl/cfg_status_reg.sv
`timescale 1ns/1ps
module cfg_status_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd7,
  input  logic       ctx_evt,
  input  logic       irq_midi,
  input  logic       irq_wss,
  input  logic       irq_sb,
  output logic [7:0] rd_data
);
  logic ctx_q, flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_q  <= 1'b0;
      flag_q <= 1'b0;
    end else if (ctx_evt) begin
      ctx_q  <= ~ctx_q;
      flag_q <= 1'b1;
    end else if (rd7) begin
      flag_q <= 1'b0;
    end
  end

  assign rd_data = {ctx_q, flag_q, irq_sb, irq_wss, irq_midi, 3'b000};

  p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd7 && !ctx_evt) |=> !flag_q);
  p_evt_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_evt |=> (flag_q && ctx_q != $past(ctx_q)));
endmodule

// File: rtl/cfg_ctrl_port.sv
`timescale 1ns/1ps
module cfg_ctrl_port
  import cfg_ctrl_pkg::*;
#(
  parameter int          RAM_AW     = 12,
  parameter logic [15:0] HWCFG_ADDR = 16'h4003,
  parameter logic [7:0]  CHIP_ID    = 8'h5C,
  parameter bit          EXT_IDX    = 1'b1,
  parameter bit          SPS_COPY   = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       i2c_scl_o,
  output logic       i2c_sda_o,
  input  logic       i2c_sda_i,
  input  logic       irq_midi_i,
  input  logic       irq_wss_i,
  input  logic       irq_sb_i,
  input  logic       ctx_evt_i,
  output logic       codec_rst_o,
  output logic       wavetable_en_o,
  output logic       fm_en_o,
  output logic       pnp_en_o,
  output logic       hwcfg_upd_o,
  output logic       resdata_upd_o,
  output logic       key_off_o
);
  logic [NUM_REGS-1:0] wsel, rsel;
  assign wsel = wr_en ? (NUM_REGS'(1) << addr) : '0;
  assign rsel = (rd_en && !wr_en) ? (NUM_REGS'(1) << addr) : '0;

  logic [7:0] r0_q, r1_q, r2_q, r5_q, r6_q;
  logic [3:0] r3_q;

  logic       in_data, cmd_hw, cmd_pnpoff, cmd_keyoff, res_upd;
  logic [7:0] ram_rd, ib_rd, st_rd;
  logic [2:0] hw_bits;
  logic       codec_rst_req;

  cfg_dl_channel #(.RAM_AW(RAM_AW), .HWCFG_ADDR(HWCFG_ADDR)) u_dl (
    .clk(clk), .rst_n(rst_n), .wr5(wsel[5]), .rd5(rsel[5]), .wr6(wsel[6]),
    .wdata(wdata), .in_data_o(in_data), .ram_rd_o(ram_rd), .cmd_hw_o(cmd_hw),
    .cmd_pnpoff_o(cmd_pnpoff), .cmd_keyoff_o(cmd_keyoff), .res_upd_o(res_upd),
    .hw_bits_o(hw_bits)
  );

  cfg_idx_bank #(.CHIP_ID(CHIP_ID), .EXT_IDX(EXT_IDX), .SPS_COPY(SPS_COPY)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wsel[4]), .idx(r3_q), .wdata(wdata),
    .hw_apply(cmd_hw), .hw_wt(hw_bits[1]), .hw_sps(hw_bits[0]),
    .rd_data(ib_rd), .codec_rst_req(codec_rst_req), .wt_en(wavetable_en_o)
  );

  cfg_status_reg u_stat (
    .clk(clk), .rst_n(rst_n), .rd7(rsel[7]), .ctx_evt(ctx_evt_i),
    .irq_midi(irq_midi_i), .irq_wss(irq_wss_i), .irq_sb(irq_sb_i), .rd_data(st_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r0_q <= 8'h00; r1_q <= 8'h80; r2_q <= 8'h00; r3_q <= 4'h0;
      r5_q <= 8'h00; r6_q <= 8'h00;
      i2c_scl_o <= 1'b1; i2c_sda_o <= 1'b1;
    end else begin
      if (wsel[0]) r0_q <= wdata;
      if (wsel[1]) begin
        r1_q <= wdata;
        if (wdata[2]) begin
          i2c_scl_o <= wdata[0];
          i2c_sda_o <= wdata[1];
        end
      end
      if (wsel[2]) r2_q <= wdata;
      if (wsel[3]) r3_q <= wdata[3:0];
      if (wsel[5]) r5_q <= wdata;
      if (wsel[6]) r6_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fm_en_o <= 1'b0; pnp_en_o <= 1'b1;
      codec_rst_o <= 1'b0; key_off_o <= 1'b0;
      hwcfg_upd_o <= 1'b1; resdata_upd_o <= 1'b1;
    end else begin
      if (cmd_hw)     fm_en_o  <= hw_bits[2];
      if (cmd_pnpoff) pnp_en_o <= 1'b0;
      codec_rst_o   <= codec_rst_req;
      key_off_o     <= cmd_keyoff;
      hwcfg_upd_o   <= cmd_hw;
      resdata_upd_o <= res_upd;
    end
  end

  always_comb begin
    unique case (addr)
      3'd0: rdata = r0_q;
      3'd1: rdata = {r1_q[7:3], r1_q[2] & i2c_sda_i, r1_q[1:0]};
      3'd2: rdata = r2_q;
      3'd3: rdata = {4'h0, r3_q};
      3'd4: rdata = ib_rd;
      3'd5: rdata = in_data ? ram_rd : r5_q;
      3'd6: rdata = r6_q;
      3'd7: rdata = st_rd;
    endcase
  end

  p_i2c_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wsel[1] && !wdata[2]) |=> ($stable(i2c_scl_o) && $stable(i2c_sda_o)));
  p_pnp_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pnpoff |=> (!pnp_en_o && hwcfg_upd_o));
  p_codec_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    codec_rst_o |=> !codec_rst_o || $past(codec_rst_req));
  p_res_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_upd |=> resdata_upd_o);
endmodule

// File: tb/cfg_ctrl_port_test.sv
`timescale 1ns/1ps
module cfg_ctrl_port_test;
  localparam logic [7:0] CHIP = 8'h5C;
  localparam int WD_LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic scl, sda, sda_i = 1'b1;
  logic irq_m = 1'b0, irq_w = 1'b0, irq_s = 1'b0, ctx_evt = 1'b0;
  logic codec_rst, wt_en, fm_en, pnp_en, hw_upd, res_upd, key_off;

  always #5 clk = ~clk;

  cfg_ctrl_port uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .i2c_scl_o(scl), .i2c_sda_o(sda),
    .i2c_sda_i(sda_i), .irq_midi_i(irq_m), .irq_wss_i(irq_w), .irq_sb_i(irq_s),
    .ctx_evt_i(ctx_evt), .codec_rst_o(codec_rst), .wavetable_en_o(wt_en),
    .fm_en_o(fm_en), .pnp_en_o(pnp_en), .hwcfg_upd_o(hw_upd),
    .resdata_upd_o(res_upd), .key_off_o(key_off)
  );

  int vecs = 0, fails = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // Reference model
  logic [7:0] m_r0, m_r1, m_r2, m_r5, m_r6;
  logic [3:0] m_r3;
  logic [7:0] m_ind [16];
  int         m_phase;
  int         m_addr;
  logic [7:0] m_ram [int];
  logic [7:0] m_hw;
  logic       m_ctx, m_flag, m_scl, m_sda, m_fm, m_pnp;
  logic       m_crst, m_hwu, m_resu, m_koff;

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_r0;
      3'd1: return {m_r1[7:3], m_r1[2] & sda_i, m_r1[1:0]};
      3'd2: return m_r2;
      3'd3: return {4'h0, m_r3};
      3'd4: return m_ind[m_r3];
      3'd5: return (m_phase == 3) ? m_ram[m_addr % 4096] : m_r5;
      3'd6: return m_r6;
      default: return {m_ctx, m_flag, irq_s, irq_w, irq_m, 3'b000};
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_r0 = 0; m_r1 = 8'h80; m_r2 = 0; m_r3 = 0; m_r5 = 0; m_r6 = 0;
      for (int i = 0; i < 16; i++) m_ind[i] = 0;
      m_ind[1] = CHIP; m_phase = 0; m_addr = 0; m_hw = 0;
      m_ctx = 0; m_flag = 0; m_scl = 1; m_sda = 1; m_fm = 0; m_pnp = 1;
      m_crst = 0; m_hwu = 1; m_resu = 1; m_koff = 0;
    end else begin
      m_crst = 0; m_hwu = 0; m_resu = 0; m_koff = 0;
      if (wr_en) begin
        case (addr)
          3'd0: m_r0 = wdata;
          3'd1: begin m_r1 = wdata; if (wdata[2]) begin m_scl = wdata[0]; m_sda = wdata[1]; end end
          3'd2: m_r2 = wdata;
          3'd3: m_r3 = wdata[3:0];
          3'd4: begin
            if (m_r3 == 0) begin m_ind[0] = 0; m_crst = wdata[7]; end
            else if (m_r3 == 2 || m_r3 == 6) m_ind[m_r3] = wdata;
            else if (m_r3 == 3) m_ind[3] = wdata & 8'hE0;
            else if (m_r3 == 4) m_ind[4] = wdata & 8'hF0;
            else if (m_r3 == 5) m_ind[5] = wdata & 8'hFE;
            else if (m_r3 == 8) m_ind[8] = wdata & 8'h0F;
          end
          3'd5: begin
            m_r5 = wdata;
            if (m_phase == 0) begin
              if (wdata == 8'hAA) m_phase = 1;
              if (wdata == 8'h55 || wdata == 8'h5A) begin
                m_hwu = 1; m_fm = m_hw[7];
                m_ind[8][3] = m_hw[3]; m_ind[8][2] = m_hw[2];
                if (wdata == 8'h55) m_pnp = 0;
              end
              if (wdata == 8'h56) m_koff = 1;
            end else if (m_phase == 1) begin m_addr = wdata; m_phase = 2; end
            else if (m_phase == 2) begin m_addr = m_addr + 256 * wdata; m_phase = 3; end
            else begin
              m_ram[m_addr % 4096] = wdata;
              if (m_addr == 16'h4003) m_hw = wdata;
              m_addr = (m_addr + 1) % 65536;
            end
          end
          3'd6: begin m_r6 = wdata; if (wdata == 8'h00 || wdata == 8'h40) begin m_phase = 0; m_resu = 1; end end
          default: ;
        endcase
      end else if (rd_en) begin
        if (addr == 3'd5 && m_phase == 3) m_addr = (m_addr + 1) % 65536;
        if (addr == 3'd7 && !ctx_evt) m_flag = 0;
      end
      if (ctx_evt) begin m_ctx = ~m_ctx; m_flag = 1; end
    end
  end

  // Per-cycle comparison of registered outputs
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R10 scl", {7'b0, scl}, {7'b0, m_scl});
      chk("R10 sda", {7'b0, sda}, {7'b0, m_sda});
      chk("R6 codec_rst", {7'b0, codec_rst}, {7'b0, m_crst});
      chk("R7 wavetable_en", {7'b0, wt_en}, {7'b0, m_ind[8][3]});
      chk("R8 fm_en", {7'b0, fm_en}, {7'b0, m_fm});
      chk("R5 pnp_en", {7'b0, pnp_en}, {7'b0, m_pnp});
      chk("R5 hwcfg_upd", {7'b0, hw_upd}, {7'b0, m_hwu});
      chk("R4 resdata_upd", {7'b0, res_upd}, {7'b0, m_resu});
      chk("R5 key_off", {7'b0, key_off}, {7'b0, m_koff});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; rd_en = 0; addr = a; wdata = d;
  endtask
  task automatic rd(input logic [2:0] a, input string req);
    @(negedge clk); wr_en = 0; rd_en = 1; addr = a;
    #1 chk(req, rdata, exp_rd(a));
  endtask
  task automatic idle();
    @(negedge clk); wr_en = 0; rd_en = 0;
  endtask
  task automatic idx_wr_rd(input logic [3:0] i, input logic [7:0] d, input string req);
    wr(3'd3, {4'h0, i}); wr(3'd4, d); rd(3'd4, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      fails++;
      $display("FAIL watchdog: got %0d expected <= %0d cycles", cyc, WD_LIMIT);
      finish_run();
    end
  end

  initial begin
    // R11: state while reset is held
    repeat (3) @(negedge clk);
    chk("R11 hwcfg_upd in reset", {7'b0, hw_upd}, 8'h01);
    chk("R11 resdata_upd in reset", {7'b0, res_upd}, 8'h01);
    chk("R11 pnp_en in reset", {7'b0, pnp_en}, 8'h01);
    chk("R11 i2c lines in reset", {6'b0, scl, sda}, 8'h03);
    addr = 3'd1; #1 chk("R11 reg1 reset", rdata, 8'h80);
    addr = 3'd4; #1 chk("R11 idx0 reset", rdata, 8'h00);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) rd(a[2:0], "R11 register after reset");
    wr(3'd3, 8'h01); rd(3'd4, "R6 chip id");

    // R1
    wr(3'd3, 8'hF2); rd(3'd3, "R1 index mask");
    idx_wr_rd(4'd2, 8'h5A, "R7 idx2 unmasked");
    idx_wr_rd(4'd3, 8'hFF, "R7 idx3 mask");
    idx_wr_rd(4'd4, 8'hFF, "R7 idx4 mask");
    idx_wr_rd(4'd5, 8'hFF, "R7 idx5 mask");
    idx_wr_rd(4'd6, 8'hA5, "R7 idx6 unmasked");
    idx_wr_rd(4'd1, 8'hFF, "R6 idx1 ignored");
    idx_wr_rd(4'd7, 8'hFF, "R6 idx7 ignored");
    for (int i = 9; i < 16; i++) idx_wr_rd(i[3:0], 8'hFF, "R6 upper idx ignored");
    idx_wr_rd(4'd0, 8'h80, "R6 idx0 reset write");
    idx_wr_rd(4'd0, 8'h13, "R6 idx0 plain write");
    idx_wr_rd(4'd8, 8'hFF, "R7 idx8 mask");
    idx_wr_rd(4'd8, 8'h00, "R7 idx8 clear");
    rd(3'd2, "R1 direct reg2 intact");

    // R2/R3: download starting at 0x4003
    wr(3'd5, 8'hAA); wr(3'd5, 8'h03); wr(3'd5, 8'h40);
    wr(3'd5, 8'h8C); wr(3'd5, 8'h11); wr(3'd5, 8'h22);
    wr(3'd6, 8'h12); rd(3'd6, "R4 non-end value stored");
    wr(3'd5, 8'h33);
    wr(3'd6, 8'h00); idle();
    rd(3'd5, "R3 command-mode read of reg5");
    wr(3'd5, 8'hAA); wr(3'd5, 8'h03); wr(3'd5, 8'h40);
    for (int k = 0; k < 4; k++) rd(3'd5, "R3 data read with increment");
    wr(3'd6, 8'h40); idle();
    // alias write at 0x0003 must not alter captured config byte
    wr(3'd5, 8'hAA); wr(3'd5, 8'h03); wr(3'd5, 8'h00); wr(3'd5, 8'h01);
    wr(3'd6, 8'h00);
    wr(3'd5, 8'hAA); wr(3'd5, 8'h03); wr(3'd5, 8'h40);
    rd(3'd5, "R2 aliased storage");
    wr(3'd6, 8'h00); idle();

    // R5/R8 commands
    wr(3'd5, 8'h57); idle();
    wr(3'd5, 8'h5A); idle();
    wr(3'd3, 8'h08); rd(3'd4, "R8 idx8 after config update");
    wr(3'd5, 8'h56); idle();
    wr(3'd5, 8'h55); idle(); idle();
    rd(3'd5, "R5 reg5 holds last command");

    // R9 status
    irq_m = 1; irq_s = 1; rd(3'd7, "R9 live irqs");
    irq_m = 0; irq_w = 1; irq_s = 0; rd(3'd7, "R9 live irqs pattern 2");
    @(negedge clk); wr_en = 0; rd_en = 0; ctx_evt = 1;
    @(negedge clk); ctx_evt = 0;
    rd(3'd7, "R9 flag set after event");
    rd(3'd7, "R9 flag cleared by read");
    @(negedge clk); wr_en = 0; rd_en = 1; addr = 3'd7; ctx_evt = 1;
    @(negedge clk); rd_en = 0; ctx_evt = 0;
    rd(3'd7, "R9 event wins over read");
    wr(3'd7, 8'hFF); rd(3'd7, "R9 write ignored");

    // R10 I2C
    wr(3'd1, 8'h07); idle();
    wr(3'd1, 8'h04); idle();
    wr(3'd1, 8'h03); idle();
    sda_i = 1; rd(3'd1, "R10 gated data read");
    wr(3'd1, 8'h04); sda_i = 1; rd(3'd1, "R10 data line high");
    sda_i = 0; rd(3'd1, "R10 data line low");
    idle(); idle();
    finish_run();
  end
endmodule